// File: doc/BRIEF.md
# Externally Clocked TDM Serial Transmitter

This block shifts one framed link out onto a system-side serial bus. The bit clock and the frame pulse of that bus come from outside. The block never generates either one. Instead, a fast internal clock oversamples both pins, and the block acts on the edges it detects. Channel bytes and their 4-bit signaling codes are fetched through a combinational read port: the block presents a source channel index and receives the byte and its code in the same cycle. It then emits a serial data bit and a serial signaling bit for every bit period, most significant bit first.

A frame is 32 timeslots of 8 bits, which is 256 bit periods. Static configuration inputs select several things independently:
- the bit-clock edge on which the frame pulse is sampled;
- the edge that launches data;
- the polarity of the frame pulse;
- a 2x clock mode, in which each bit period holds two active edges, and a select that picks which of the two launches data;
- a bit offset and a timeslot offset, which delay the frame start relative to the pulse.

An optional mapping places a 24-channel link into the 32-slot frame. The framing bit goes in slot 0, the channels go in the slots that follow, and filler fills the rest. Each input level, `sclk_in` and `fsync_in`, must stay stable for at least two `clk` cycles.

Top module: `tdm_slave_tx`

## Requirements
- R1: After reset, `sd_out` and `sig_out` are both 1, and the frame position counter is 0.
- R2: In 1x mode, one bit is launched per `sclk_in` period, on the rising edge when `cfg_tx_fall`=0 and on the falling edge when it is 1. Launched bits walk the frame position upward, and within each slot the MSB goes first. Both outputs change on the third `clk` rising edge after the `sclk_in` transition.
- R3: The frame pulse is sampled on the rising edge when `cfg_fs_fall`=0 and on the falling edge when it is 1. A recognised pulse makes frame position (256 − (8·`cfg_slot_ofs` + `cfg_bit_ofs`)) mod 256 the next bit launched. If the sampling edge is also the launch edge, that bit is launched on that same edge. Otherwise it is launched on the next launch edge.
- R4: The frame pulse is active high when `cfg_fs_low`=0 and active low when it is 1.
- R5: A pulse is recognised only at the first sampling edge that finds it active. Further sampling edges that find it still active do not restart the frame.
- R6: With `cfg_dbl_rate`=1, each bit period spans two launch-type edges. A recognised pulse sets the next launch-type edge as the first edge of a bit period; a coincident edge counts as that next edge. From then on the edges alternate first, second. Data is launched only on first edges when `cfg_late_half`=0, and only on second edges when it is 1.
- R7: With `cfg_t1_map`=0, timeslot n reads source index n. Its data byte is `rd_byte`, and its signaling byte is {4'b1111, `rd_sig`}.
- R8: With `cfg_t1_map`=1, timeslot 0 carries {`t1_fbit`, 7'b1111111} with signaling 8'hFF. Timeslots 1 to 24 read source index slot−1 and use the R7 byte forms. Timeslots 25 to 31 output 8'hFF on both data and signaling.
- R9: Without frame pulses the position keeps counting, wrapping from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | External bit clock (1x or 2x) |
| fsync_in | input | 1 | External frame pulse |
| cfg_fs_fall | input | 1 | Frame pulse sampled on falling edge when 1 |
| cfg_tx_fall | input | 1 | Data launched on falling edge when 1 |
| cfg_dbl_rate | input | 1 | Bit clock runs at twice the bit rate |
| cfg_late_half | input | 1 | In 2x mode, launch on the second edge of each bit |
| cfg_fs_low | input | 1 | Frame pulse active low |
| cfg_t1_map | input | 1 | Enable 24-channel into 32-slot mapping |
| cfg_bit_ofs | input | 3 | Bit offset of frame start after the pulse |
| cfg_slot_ofs | input | 5 | Timeslot offset of frame start after the pulse |
| t1_fbit | input | 1 | Framing bit placed in slot 0 when mapping |
| rd_byte | input | 8 | Channel byte for `rd_slot` |
| rd_sig | input | 4 | Signaling code for `rd_slot` |
| rd_slot | output | 5 | Source channel index being fetched |
| sd_out | output | 1 | Serial data |
| sig_out | output | 1 | Serial signaling |

## Verification
The bench targets the following corner cases:
- **Sampling edge differs from the launch edge.** A design that launched too early or too late here would shift the whole frame by a bit.
- **Coincident sampling and launch edges.** A design that ignored the pulse on that shared edge would be one bit late.
- **Maximum offsets.** With a slot offset of 31 and a bit offset of 7, the start position wraps to 1. A design that got the wrap wrong would misplace both data and signaling.
- **Pulse held across several sampling edges.** A design that re-triggered on each edge would keep restarting the frame.
- **2x mode with either launch select.** Wrong phase tracking would repeat or skip bits.
- **Mapped slot 0 and filler slots.** Reading channel memory there would put the wrong bytes on the bus.
- **No pulses at all.** A run without pulses shows whether the counter wraps.

// File: rtl/tdm_slave_tx_pkg.sv
package tdm_slave_tx_pkg;

    localparam int SLOT_BITS   = 8;
    localparam int FRAME_SLOTS = 32;
    localparam int SIG_W       = 4;
    localparam int T1_CHANNELS = 24;
    localparam int FRAME_BITS  = FRAME_SLOTS * SLOT_BITS;
    localparam int POS_W       = $clog2(FRAME_BITS);
    localparam int TS_W        = $clog2(FRAME_SLOTS);
    localparam int BIT_W       = $clog2(SLOT_BITS);

    typedef logic [POS_W-1:0]     pos_t;
    typedef logic [TS_W-1:0]      ts_t;
    typedef logic [BIT_W-1:0]     bidx_t;
    typedef logic [SLOT_BITS-1:0] byte_t;

    typedef struct packed {
        logic  fs_fall;
        logic  tx_fall;
        logic  dbl;
        logic  late;
        logic  fs_low;
        logic  t1_map;
        bidx_t bit_ofs;
        ts_t   slot_ofs;
    } cfg_t;

    typedef struct packed {
        byte_t data;
        byte_t sig;
    } slot_word_t;

    // Frame position launched first after a recognised pulse.
    function automatic pos_t start_of(input ts_t slot_ofs, input bidx_t bit_ofs);
        int ofs;
        ofs = int'(slot_ofs) * SLOT_BITS + int'(bit_ofs);
        return pos_t'((FRAME_BITS - ofs) % FRAME_BITS);
    endfunction

endpackage

// File: rtl/tdm_slave_tx_sync.sv
module tdm_slave_tx_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] chain;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= din;
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= chain[s-1];
            end
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/tdm_slave_tx_timing.sv
module tdm_slave_tx_timing
    import tdm_slave_tx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sclk_lvl,
    input  logic fs_lvl,
    input  logic fs_fall,
    input  logic tx_fall,
    input  logic dbl,
    input  logic late,
    input  logic fs_low,
    input  pos_t start_pos,
    output logic fs_hit,
    output logic tx_evt,
    output logic launch_evt,
    output pos_t launch_pos,
    output pos_t cur_pos
);
    logic sclk_d;
    logic fs_prev;
    logic ph;
    logic rise, fall, fs_evt, fs_act, ph_now;

    assign rise   = sclk_lvl & ~sclk_d;
    assign fall   = ~sclk_lvl & sclk_d;
    assign fs_evt = fs_fall ? fall : rise;
    assign tx_evt = tx_fall ? fall : rise;
    assign fs_act = fs_lvl ^ fs_low;
    assign fs_hit = fs_evt & fs_act & ~fs_prev;

    // Bit-period phase seen by the current launch-type edge.
    assign ph_now     = fs_hit ? 1'b0 : ph;
    assign launch_evt = tx_evt & (~dbl | (ph_now == late));
    assign launch_pos = fs_hit ? start_pos : cur_pos;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d  <= 1'b0;
            fs_prev <= 1'b0;
            ph      <= 1'b0;
            cur_pos <= '0;
        end else begin
            sclk_d <= sclk_lvl;
            if (fs_evt) fs_prev <= fs_act;
            if (launch_evt)  cur_pos <= pos_t'(launch_pos + 1'b1);
            else if (fs_hit) cur_pos <= start_pos;
            if (tx_evt)      ph <= ~ph_now;
            else if (fs_hit) ph <= 1'b0;
        end
    end
endmodule

// File: rtl/tdm_slave_tx_slotmap.sv
module tdm_slave_tx_slotmap
    import tdm_slave_tx_pkg::*;
(
    input  logic             t1_map,
    input  logic             fbit,
    input  ts_t              ts,
    input  byte_t            rd_byte,
    input  logic [SIG_W-1:0] rd_sig,
    output ts_t              rd_slot,
    output slot_word_t       word
);
    localparam byte_t ONES = '1;

    always_comb begin
        rd_slot   = ts;
        word.data = rd_byte;
        word.sig  = {{(SLOT_BITS-SIG_W){1'b1}}, rd_sig};
        if (t1_map) begin
            if (ts == '0) begin
                word.data = {fbit, {(SLOT_BITS-1){1'b1}}};
                word.sig  = ONES;
            end else if (int'(ts) <= T1_CHANNELS) begin
                rd_slot = ts_t'(ts - 1'b1);
            end else begin
                word.data = ONES;
                word.sig  = ONES;
            end
        end
    end
endmodule

// File: rtl/tdm_slave_tx.sv
module tdm_slave_tx
    import tdm_slave_tx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sclk_in,
    input  logic             fsync_in,
    input  logic             cfg_fs_fall,
    input  logic             cfg_tx_fall,
    input  logic             cfg_dbl_rate,
    input  logic             cfg_late_half,
    input  logic             cfg_fs_low,
    input  logic             cfg_t1_map,
    input  logic [BIT_W-1:0] cfg_bit_ofs,
    input  logic [TS_W-1:0]  cfg_slot_ofs,
    input  logic             t1_fbit,
    input  logic [SLOT_BITS-1:0] rd_byte,
    input  logic [SIG_W-1:0] rd_sig,
    output logic [TS_W-1:0]  rd_slot,
    output logic             sd_out,
    output logic             sig_out
);
    cfg_t       cfg;
    logic [1:0] pins_sync;
    pos_t       start_pos, launch_pos, cur_pos;
    logic       fs_hit, tx_evt, launch_evt;
    slot_word_t word;
    bidx_t      bit_idx;

    assign cfg = '{fs_fall: cfg_fs_fall, tx_fall: cfg_tx_fall, dbl: cfg_dbl_rate,
                   late: cfg_late_half, fs_low: cfg_fs_low, t1_map: cfg_t1_map,
                   bit_ofs: cfg_bit_ofs, slot_ofs: cfg_slot_ofs};

    assign start_pos = start_of(cfg.slot_ofs, cfg.bit_ofs);

    tdm_slave_tx_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({fsync_in, sclk_in}),
        .dout (pins_sync)
    );

    tdm_slave_tx_timing u_timing (
        .clk        (clk),
        .rst        (rst),
        .sclk_lvl   (pins_sync[0]),
        .fs_lvl     (pins_sync[1]),
        .fs_fall    (cfg.fs_fall),
        .tx_fall    (cfg.tx_fall),
        .dbl        (cfg.dbl),
        .late       (cfg.late),
        .fs_low     (cfg.fs_low),
        .start_pos  (start_pos),
        .fs_hit     (fs_hit),
        .tx_evt     (tx_evt),
        .launch_evt (launch_evt),
        .launch_pos (launch_pos),
        .cur_pos    (cur_pos)
    );

    tdm_slave_tx_slotmap u_map (
        .t1_map  (cfg.t1_map),
        .fbit    (t1_fbit),
        .ts      (launch_pos[POS_W-1:BIT_W]),
        .rd_byte (rd_byte),
        .rd_sig  (rd_sig),
        .rd_slot (rd_slot),
        .word    (word)
    );

    assign bit_idx = launch_pos[BIT_W-1:0];

    // MSB first: bit index 0 selects the top bit of the slot byte.
    always_ff @(posedge clk) begin
        if (rst) begin
            sd_out  <= 1'b1;
            sig_out <= 1'b1;
        end else if (launch_evt) begin
            sd_out  <= word.data[~bit_idx];
            sig_out <= word.sig[~bit_idx];
        end
    end
endmodule

// File: rtl/tdm_slave_tx_chk.sv
module tdm_slave_tx_chk
    import tdm_slave_tx_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic sd_out,
    input logic sig_out,
    input logic launch_evt,
    input logic fs_hit,
    input pos_t cur_pos,
    input pos_t start_pos,
    input ts_t  launch_ts,
    input logic cfg_t1_map
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        $fell(rst) |-> (sd_out && sig_out));

    assert_change_only_on_launch_R2: assert property (@(posedge clk) disable iff (rst)
        ((sd_out != $past(sd_out)) || (sig_out != $past(sig_out))) |-> $past(launch_evt));

    assert_pulse_loads_start_R3: assert property (@(posedge clk) disable iff (rst)
        (fs_hit && !launch_evt) |=> (cur_pos == $past(start_pos)));

    assert_filler_ones_R8: assert property (@(posedge clk) disable iff (rst)
        (launch_evt && cfg_t1_map && (int'(launch_ts) > T1_CHANNELS)) |=> (sd_out && sig_out));
endmodule

bind tdm_slave_tx tdm_slave_tx_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .sd_out     (sd_out),
    .sig_out    (sig_out),
    .launch_evt (launch_evt),
    .fs_hit     (fs_hit),
    .cur_pos    (cur_pos),
    .start_pos  (start_pos),
    .launch_ts  (launch_pos[tdm_slave_tx_pkg::POS_W-1:tdm_slave_tx_pkg::BIT_W]),
    .cfg_t1_map (cfg_t1_map)
);

// File: tb/tdm_slave_tx_test.sv
module tdm_slave_tx_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk_in = 1'b0, fsync_in = 1'b0;
    logic cfg_fs_fall = 0, cfg_tx_fall = 0, cfg_dbl_rate = 0, cfg_late_half = 0;
    logic cfg_fs_low = 0, cfg_t1_map = 0, t1_fbit = 0;
    logic [2:0] cfg_bit_ofs = 0;
    logic [4:0] cfg_slot_ofs = 0;
    logic [7:0] rd_byte;
    logic [3:0] rd_sig;
    logic [4:0] rd_slot;
    logic sd_out, sig_out;

    logic [7:0] mem_byte [32];
    logic [3:0] mem_sig  [32];

    int checks = 0;
    int bad = 0;
    bit done = 0;
    string cur_req = "R2";

    // Reference model state
    int m_pos, m_ph;
    bit m_prev;
    logic [1:0] exp_now;
    logic [1:0] hist [3];

    always #5 clk = ~clk;

    assign rd_byte = mem_byte[rd_slot];
    assign rd_sig  = mem_sig[rd_slot];

    tdm_slave_tx uut (
        .clk(clk), .rst(rst), .sclk_in(sclk_in), .fsync_in(fsync_in),
        .cfg_fs_fall(cfg_fs_fall), .cfg_tx_fall(cfg_tx_fall),
        .cfg_dbl_rate(cfg_dbl_rate), .cfg_late_half(cfg_late_half),
        .cfg_fs_low(cfg_fs_low), .cfg_t1_map(cfg_t1_map),
        .cfg_bit_ofs(cfg_bit_ofs), .cfg_slot_ofs(cfg_slot_ofs),
        .t1_fbit(t1_fbit), .rd_byte(rd_byte), .rd_sig(rd_sig),
        .rd_slot(rd_slot), .sd_out(sd_out), .sig_out(sig_out)
    );

    task automatic check(input logic [1:0] act, input logic [1:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s at %0t: {sd,sig} actual=%b expected=%b", req, $time, act, exp);
        end
    endtask

    // Expected {data, signaling} bits at frame position p (R7, R8).
    function automatic logic [1:0] exp_bits(input int p);
        int ts = p / 8;
        int b  = p % 8;
        logic [7:0] d, s;
        if (!cfg_t1_map) begin
            d = mem_byte[ts]; s = {4'hF, mem_sig[ts]};
        end else if (ts == 0) begin
            d = {t1_fbit, 7'h7F}; s = 8'hFF;
        end else if (ts <= 24) begin
            d = mem_byte[ts-1]; s = {4'hF, mem_sig[ts-1]};
        end else begin
            d = 8'hFF; s = 8'hFF;
        end
        return {d[7-b], s[7-b]};
    endfunction

    task automatic model_edge(input bit rising);
        bit fe = rising ? !cfg_fs_fall : cfg_fs_fall;
        bit de = rising ? !cfg_tx_fall : cfg_tx_fall;
        bit act = (fsync_in != cfg_fs_low);
        bit hit = 0;
        int start = (256 - (cfg_slot_ofs * 8 + cfg_bit_ofs)) % 256;
        if (fe) begin
            hit = act && !m_prev;
            m_prev = act;
        end
        if (de) begin
            int phc = hit ? 0 : m_ph;
            bit go = !cfg_dbl_rate || (phc == int'(cfg_late_half));
            m_ph = 1 - phc;
            if (go) begin
                int p = hit ? start : m_pos;
                exp_now = exp_bits(p);
                m_pos = (p + 1) % 256;
            end else if (hit) begin
                m_pos = start;
            end
        end else if (hit) begin
            m_pos = start;
            m_ph = 0;
        end
    endtask

    // R1: reset state, then model restart.
    task automatic do_reset(input int seed);
        rst = 1; sclk_in = 0; fsync_in = cfg_fs_low;
        for (int i = 0; i < 32; i++) begin
            mem_byte[i] = 8'(i * 37 + seed * 11 + 5);
            mem_sig[i]  = 4'(i * 3 + seed);
        end
        repeat (3) @(negedge clk);
        rst = 0;
        m_pos = 0; m_ph = 0; m_prev = 0; exp_now = 2'b11;
        for (int i = 0; i < 3; i++) hist[i] = 2'b11;
        @(negedge clk);
        check({sd_out, sig_out}, 2'b11, "R1");
    endtask

    // Drive half-periods of sclk, pulse active over [first + k*period, +len) halves.
    task automatic run(input int halves, input int first, input int period, input int len);
        for (int h = 0; h < halves; h++) begin
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                check({sd_out, sig_out}, hist[2], cur_req);
                hist[2] = hist[1];
                hist[1] = hist[0];
                if (i == 0) begin
                    sclk_in = ~sclk_in;
                    model_edge(sclk_in);
                end
                if (i == 2) begin
                    bit on = (h >= first) && (((h - first) % period) < len);
                    fsync_in = on ? !cfg_fs_low : cfg_fs_low;
                end
                hist[0] = exp_now;
            end
        end
    endtask

    initial begin
        // R2 R7 R9: 1x, rising edges, direct mapping, no offset
        cur_req = "R2/R7/R9";
        do_reset(1);
        run(1100, 6, 512, 2);

        // R3 R8: pulse on falling, data on rising, offsets, mapped
        cfg_fs_fall = 1; cfg_tx_fall = 0; cfg_t1_map = 1; t1_fbit = 1;
        cfg_bit_ofs = 3; cfg_slot_ofs = 5;
        cur_req = "R3/R8";
        do_reset(2);
        run(1100, 9, 512, 2);

        // R3 R4 R7: same edge, active-low pulse, maximum offsets
        cfg_fs_fall = 1; cfg_tx_fall = 1; cfg_fs_low = 1; cfg_t1_map = 0;
        cfg_bit_ofs = 7; cfg_slot_ofs = 31;
        cur_req = "R3/R4/R7";
        do_reset(3);
        run(1100, 9, 512, 2);

        // R5 R9: long pulse over three sampling edges, then free running
        cfg_fs_fall = 0; cfg_tx_fall = 1; cfg_fs_low = 0;
        cfg_bit_ofs = 2; cfg_slot_ofs = 1;
        cur_req = "R5/R9";
        do_reset(4);
        run(1400, 7, 100000, 6);

        // R6 R8: 2x, first-edge launch, coincident edges
        cfg_dbl_rate = 1; cfg_late_half = 0; cfg_fs_fall = 0; cfg_tx_fall = 0;
        cfg_t1_map = 1; t1_fbit = 0; cfg_bit_ofs = 1; cfg_slot_ofs = 2;
        cur_req = "R6/R8";
        do_reset(5);
        run(2300, 5, 1024, 4);

        // R6 R5: 2x, second-edge launch, pulse edge ahead of data edge
        cfg_late_half = 1; cfg_fs_fall = 1; cfg_tx_fall = 0; cfg_t1_map = 0;
        cfg_bit_ofs = 0; cfg_slot_ofs = 0;
        cur_req = "R6/R5";
        do_reset(6);
        run(2300, 11, 1024, 4);

        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule